// File: doc/BRIEF.md
# Parallel ATA Register Access Sequencer

This block runs one register read or one register write on a parallel ATA bus, acting as the host. A request port takes a register address, a direction bit and a write byte. The block then drives the two active-low chip selects and the three device address lines. It waits out an address setup time and pulses the read or write strobe. Partway through the strobe it samples the device ready line, and if the device is holding ready low at that point the strobe is stretched. After the strobe it holds the address for a set time and waits out a recovery time. It then reports completion with a one-cycle done pulse. On a read, the captured byte is returned at the same time.

Every phase length is a parameter counted in system clocks. A timeout bounds the stretch caused by the ready line. When the timeout expires, the cycle closes normally and an error flag is raised together with done. The block has no queue: it accepts one request, ignores the request port until that request is finished, and shows this on its busy output.

Top module: `pata_reg_seq`

## Requirements
- R1: After reset, busy, done and err are 0, both chip selects and both strobes are high (negated), and the data drive enable is 0.
- R2: A request is accepted on a rising edge where req_valid is 1 and busy is 0. Busy is 1 from the next cycle until done. A request presented while busy is 1 is ignored and does not start a cycle after done.
- R3: The address bits map as follows. Address bit 3 = 0 drives ata_cs0_n low and ata_cs1_n high; bit 3 = 1 drives ata_cs1_n low and ata_cs0_n high. ata_da carries address bits 2..0. These lines are valid from the cycle after acceptance, for exactly T_SETUP cycles before the strobe falls. They stay stable until the hold phase ends, and the two chip selects are never low together.
- R4: A read pulses only ata_dior_n and a write pulses only ata_diow_n. When ready is high at the sample point, the strobe is low for exactly T_STROBE cycles.
- R5: Ready is sampled on the T_SAMPLE-th rising edge after the strobe falls. If ready went low earlier but is high again at that edge, no wait is inserted and the strobe width stays T_STROBE.
- R6: If ready is low at the sample edge, the strobe stays low until the first edge, at or after the minimum width, at which ready is high.
- R7: If the stretch reaches T_SAMPLE+T_TIMEOUT cycles of strobe with ready still low, the strobe is negated at that point and err is 1 together with done. Otherwise err stays 0.
- R8: On a read, rdata takes the value of ata_dd_in from the last strobe-low cycle. A write leaves rdata unchanged.
- R9: On a write, ata_dd_oe is 1 and ata_dd_out equals the request's write byte from the cycle after acceptance through the hold phase. On a read, ata_dd_oe is 0 throughout.
- R10: After the strobe rises, address and chip selects are held for T_HOLD cycles. Both chip selects are then high for T_RECOV cycles while busy is still 1. Done is then 1 for exactly one cycle, with busy 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 4 | Bit 3 selects the chip select, bits 2..0 the device address |
| req_wdata | input | DATA_W | Byte to write |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Ready timeout, valid with done |
| rdata | output | DATA_W | Byte captured by the last read |
| ata_cs0_n | output | 1 | Command block chip select, active low |
| ata_cs1_n | output | 1 | Control block chip select, active low |
| ata_da | output | 3 | Device address lines |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_iordy | input | 1 | Device ready, low requests a wait |
| ata_dd_in | input | DATA_W | Data lines from the device |
| ata_dd_out | output | DATA_W | Data lines to the device |
| ata_dd_oe | output | 1 | Drive enable for ata_dd_out |

## Verification
The bench moves the ready dip around the sample edge. It places a dip that ends exactly on the sample edge, one that covers the sample edge but ends before the minimum width, and one that ends exactly on the timeout edge. A design that samples one cycle off, that shortens the strobe below its minimum, or that flags an error when ready is released on the last allowed cycle gets the strobe width or err wrong. The read bus changes every strobe cycle, so capturing on the wrong edge returns a different byte. A request is also pushed in mid-cycle to catch a sequencer that takes it or queues it for later.

// File: rtl/pata_reg_pkg.sv
`timescale 1ns/1ps
package pata_reg_pkg;

   localparam int DA_W = 3;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SETUP,
      PH_STROBE,
      PH_HOLD,
      PH_RECOV
   } phase_t;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pata_phase_timer.sv
`timescale 1ns/1ps
module pata_phase_timer #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt
);

   // cycles spent in the current phase, saturating
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (clr)        cnt <= '0;
      else if (cnt != '1)  cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/pata_ready_mon.sv
`timescale 1ns/1ps
module pata_ready_mon #(
   parameter int CNT_W     = 5,
   parameter int T_STROBE  = 6,
   parameter int T_SAMPLE  = 3,
   parameter int T_TIMEOUT = 20,
   parameter int RDY_SYNC  = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             iordy,
   input  logic             in_strobe,
   input  logic [CNT_W-1:0] cnt,
   output logic             release_ok,
   output logic             tmo_err
);

   localparam logic [CNT_W-1:0] SAMPLE_AT = CNT_W'(T_SAMPLE - 1);
   localparam logic [CNT_W-1:0] MIN_AT    = CNT_W'(T_STROBE - 1);
   localparam logic [CNT_W-1:0] LAST_AT   = CNT_W'(T_SAMPLE + T_TIMEOUT - 1);

   logic rdy;
   logic wait_q;
   logic min_ok;
   logic tmo_hit;

   generate
      if (RDY_SYNC == 0) begin : g_direct
         assign rdy = iordy;
      end else begin : g_sync
         logic [RDY_SYNC-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh <= '1;
            end else begin
               sh[0] <= iordy;
               for (int i = 1; i < RDY_SYNC; i++) sh[i] <= sh[i-1];
            end
         end
         assign rdy = sh[RDY_SYNC-1];
      end
   endgenerate

   // wait decision taken once, at the sample edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      wait_q <= 1'b0;
      else if (!in_strobe)             wait_q <= 1'b0;
      else if (cnt == SAMPLE_AT)       wait_q <= !rdy;
   end

   assign min_ok     = (cnt >= MIN_AT);
   assign tmo_hit    = wait_q && (cnt == LAST_AT);
   assign release_ok = in_strobe && ((min_ok && (!wait_q || rdy)) || tmo_hit);
   assign tmo_err    = tmo_hit && !rdy;

   // a wait can only be flagged after the sample edge has passed
   assert_wait_after_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_strobe && wait_q) |-> (cnt >= CNT_W'(T_SAMPLE)));

   // the stretch never outlasts the timeout window
   assert_timeout_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_strobe |-> (cnt <= LAST_AT));

endmodule

// File: rtl/pata_reg_seq.sv
`timescale 1ns/1ps
module pata_reg_seq
   import pata_reg_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int T_SETUP   = 2,
   parameter int T_STROBE  = 6,
   parameter int T_SAMPLE  = 3,
   parameter int T_HOLD    = 2,
   parameter int T_RECOV   = 3,
   parameter int T_TIMEOUT = 20,
   parameter int RDY_SYNC  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [3:0]        req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [DATA_W-1:0] rdata,
   output logic              ata_cs0_n,
   output logic              ata_cs1_n,
   output logic [DA_W-1:0]   ata_da,
   output logic              ata_dior_n,
   output logic              ata_diow_n,
   input  logic              ata_iordy,
   input  logic [DATA_W-1:0] ata_dd_in,
   output logic [DATA_W-1:0] ata_dd_out,
   output logic              ata_dd_oe
);

   localparam int CNT_MAX = max2(max2(max2(T_SETUP, T_HOLD), T_RECOV),
                                 T_SAMPLE + T_TIMEOUT);
   localparam int CNT_W   = $clog2(CNT_MAX + 1) + 1;

   generate
      if (T_SETUP < 1 || T_HOLD < 1 || T_RECOV < 1 || T_SAMPLE < 1) begin : g_bad_len
         $error("every phase length must be at least one clock");
      end
      if (T_SAMPLE >= T_STROBE) begin : g_bad_sample
         $error("ready sample point must fall inside the minimum strobe width");
      end
      if (T_TIMEOUT < T_STROBE) begin : g_bad_tmo
         $error("timeout must not be shorter than the minimum strobe width");
      end
      if (RDY_SYNC < 0 || RDY_SYNC > 3) begin : g_bad_sync
         $error("ready synchroniser depth must be 0 to 3");
      end
      if (DATA_W < 8) begin : g_bad_width
         $error("register data needs at least 8 bits");
      end
   endgenerate

   phase_t             phase_q, phase_d;
   logic               wr_q, blk_q;
   logic [DA_W-1:0]    da_q;
   logic [DATA_W-1:0]  wdata_q, rdata_q;
   logic               done_q, tmo_q;
   logic [CNT_W-1:0]   cnt;
   logic               release_ok, tmo_err;
   logic               in_strobe, addr_phase, accept;

   assign in_strobe  = (phase_q == PH_STROBE);
   assign addr_phase = (phase_q == PH_SETUP) || in_strobe || (phase_q == PH_HOLD);
   assign accept     = (phase_q == PH_IDLE) && req_valid;

   pata_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (phase_d != phase_q),
      .cnt   (cnt)
   );

   pata_ready_mon #(
      .CNT_W     (CNT_W),
      .T_STROBE  (T_STROBE),
      .T_SAMPLE  (T_SAMPLE),
      .T_TIMEOUT (T_TIMEOUT),
      .RDY_SYNC  (RDY_SYNC)
   ) u_rdy (
      .clk        (clk),
      .rst_n      (rst_n),
      .iordy      (ata_iordy),
      .in_strobe  (in_strobe),
      .cnt        (cnt),
      .release_ok (release_ok),
      .tmo_err    (tmo_err)
   );

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_IDLE:   if (req_valid)                      phase_d = PH_SETUP;
         PH_SETUP:  if (cnt == CNT_W'(T_SETUP - 1))     phase_d = PH_STROBE;
         PH_STROBE: if (release_ok)                     phase_d = PH_HOLD;
         PH_HOLD:   if (cnt == CNT_W'(T_HOLD - 1))      phase_d = PH_RECOV;
         PH_RECOV:  if (cnt == CNT_W'(T_RECOV - 1))     phase_d = PH_IDLE;
         default:                                       phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         wr_q    <= 1'b0;
         blk_q   <= 1'b0;
         da_q    <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         done_q  <= 1'b0;
         tmo_q   <= 1'b0;
      end else begin
         phase_q <= phase_d;
         done_q  <= (phase_q == PH_RECOV) && (phase_d == PH_IDLE);
         if (accept) begin
            wr_q    <= req_write;
            blk_q   <= req_addr[3];
            da_q    <= req_addr[DA_W-1:0];
            wdata_q <= req_wdata;
            tmo_q   <= 1'b0;
         end
         if (in_strobe && release_ok) begin
            tmo_q <= tmo_err;
            if (!wr_q) rdata_q <= ata_dd_in;
         end
      end
   end

   assign busy       = (phase_q != PH_IDLE);
   assign done       = done_q;
   assign err        = done_q && tmo_q;
   assign rdata      = rdata_q;
   assign ata_cs0_n  = !(addr_phase && !blk_q);
   assign ata_cs1_n  = !(addr_phase && blk_q);
   assign ata_da     = addr_phase ? da_q : '0;
   assign ata_dior_n = !(in_strobe && !wr_q);
   assign ata_diow_n = !(in_strobe && wr_q);
   assign ata_dd_out = wdata_q;
   assign ata_dd_oe  = addr_phase && wr_q;

   assert_single_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ata_cs0_n && !ata_cs1_n));

   assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ata_dior_n || !ata_diow_n) |->
         ($stable(ata_da) && $stable(ata_cs0_n) && $stable(ata_cs1_n)));

   assert_setup_before_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ata_dior_n && ata_diow_n) |-> $past(!ata_cs0_n || !ata_cs1_n));

   assert_no_drive_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ata_dior_n |-> !ata_dd_oe);

   assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && ata_cs0_n && ata_cs1_n));

   assert_err_only_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);

   assert_busy_until_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

endmodule

// File: tb/tb_pata_reg_seq.sv
`timescale 1ns/1ps
module tb_pata_reg_seq;

   localparam int TSET = 2;
   localparam int TSTR = 6;
   localparam int TSMP = 3;
   localparam int THLD = 2;
   localparam int TREC = 3;
   localparam int TTMO = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_write = 1'b0;
   logic [3:0] req_addr = '0;
   logic [7:0] req_wdata = '0;
   logic       busy, done, err;
   logic [7:0] rdata;
   logic       ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n;
   logic [2:0] ata_da;
   logic       ata_iordy = 1'b1;
   logic [7:0] ata_dd_in = '0;
   logic [7:0] ata_dd_out;
   logic       ata_dd_oe;

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] last_rd = 8'h00;

   always #2.5 clk = ~clk;

   pata_reg_seq #(
      .T_SETUP(TSET), .T_STROBE(TSTR), .T_SAMPLE(TSMP),
      .T_HOLD(THLD), .T_RECOV(TREC), .T_TIMEOUT(TTMO)
   ) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
      .err(err), .rdata(rdata), .ata_cs0_n(ata_cs0_n), .ata_cs1_n(ata_cs1_n),
      .ata_da(ata_da), .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n),
      .ata_iordy(ata_iordy), .ata_dd_in(ata_dd_in), .ata_dd_out(ata_dd_out),
      .ata_dd_oe(ata_dd_oe)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit wait_exp(input int lf, input int lt);
      return (lf <= TSMP) && (TSMP < lt);
   endfunction

   function automatic int width_exp(input int lf, input int lt);
      int w;
      if (!wait_exp(lf, lt)) return TSTR;
      w = (lt > TSTR) ? lt : TSTR;
      if (w > TSMP + TTMO) w = TSMP + TTMO;
      return w;
   endfunction

   function automatic bit err_exp(input int lf, input int lt);
      return wait_exp(lf, lt) && (lt > TSMP + TTMO);
   endfunction

   function automatic logic [7:0] bus_pat(input int seed, input int j);
      return 8'((seed * 37 + j * 11 + 5) & 255);
   endfunction

   // ready is low while the strobe-low cycle count j lies in [lf, lt)
   task automatic run(input bit wr, input logic [3:0] addr, input logic [7:0] wd,
                      input int lf, input int lt, input int seed, input bit poke);
      int j = 0, setup_n = 0, strobe_n = 0, hold_n = 0, recov_n = 0;
      bit addr_ok = 1, oe_ok = 1, dir_ok = 1, got_done = 0;
      int w_e = width_exp(lf, lt);
      string wtag;
      if (wait_exp(lf, lt))              wtag = "R6";
      else if (lf < lt && lf <= TSMP)    wtag = "R5";
      else                               wtag = "R4";
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
      ata_iordy = 1'b1; ata_dd_in = bus_pat(seed, 0);
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy === 1'b1, "R2 busy after accept", int'(busy), 1);
      for (int k = 1; k < 200; k++) begin
         bit cs_act = !ata_cs0_n || !ata_cs1_n;
         bit st_low = wr ? !ata_diow_n : !ata_dior_n;
         bit st_bad = wr ? !ata_dior_n : !ata_diow_n;
         if (done) begin got_done = 1; break; end
         if (st_bad) dir_ok = 0;
         if (st_low) begin j++; strobe_n++; end
         else if (cs_act && j == 0) setup_n++;
         else if (cs_act) hold_n++;
         else if (busy) recov_n++;
         if (cs_act) begin
            if (ata_cs0_n !== addr[3] || ata_cs1_n !== !addr[3] || ata_da !== addr[2:0])
               addr_ok = 0;
            if (wr ? (ata_dd_oe !== 1'b1 || ata_dd_out !== wd) : (ata_dd_oe !== 1'b0))
               oe_ok = 0;
         end else if (ata_dd_oe !== 1'b0) oe_ok = 0;
         if (poke && k == 2) begin
            req_valid = 1'b1; req_write = !wr; req_addr = ~addr; req_wdata = ~wd;
         end
         if (poke && k == 5) req_valid = 1'b0;
         ata_iordy = !((j >= lf) && (j < lt));
         ata_dd_in = bus_pat(seed, j);
         @(negedge clk);
      end
      chk(got_done, "R10 done reached", int'(got_done), 1);
      chk(setup_n == TSET, "R3 setup cycles", setup_n, TSET);
      chk(addr_ok, "R3 chip select and address", int'(addr_ok), 1);
      chk(dir_ok, "R4 strobe direction", int'(dir_ok), 1);
      chk(strobe_n == w_e, {wtag, " strobe width"}, strobe_n, w_e);
      chk(hold_n == THLD, "R10 hold cycles", hold_n, THLD);
      chk(recov_n == TREC, "R10 recovery cycles", recov_n, TREC);
      chk(err == err_exp(lf, lt), "R7 error flag", int'(err), int'(err_exp(lf, lt)));
      chk(oe_ok, "R9 data drive", int'(oe_ok), 1);
      if (!wr) last_rd = bus_pat(seed, w_e);
      chk(rdata == last_rd, "R8 read data", int'(rdata), int'(last_rd));
      ata_iordy = 1'b1;
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, "R2 R10 single done, no stale start",
          int'({done, busy}), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int s;
      s = int'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 0 && done == 0 && err == 0, "R1 status idle", int'({busy, done, err}), 0);
      chk(ata_cs0_n && ata_cs1_n && ata_dior_n && ata_diow_n && !ata_dd_oe,
          "R1 bus idle", int'({ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n, ata_dd_oe}), 30);
      // directed corner cases
      run(0, 4'h7, 8'h00, 99, 99, 1, 0);             // R4 no wait, read, command block
      run(1, 4'hE, 8'hA5, 99, 99, 2, 0);             // R4 write, control block
      run(0, 4'h2, 8'h00, 1, TSMP, 3, 0);            // R5 released on the sample edge
      run(1, 4'h9, 8'h3C, 2, TSMP + 1, 4, 0);        // R6 low at sample, gone before min width
      run(0, 4'h5, 8'h00, TSMP, 10, 5, 0);           // R6 stretch to 10
      run(1, 4'h1, 8'h77, 1, 12, 6, 0);              // R8 write leaves rdata alone
      run(0, 4'h3, 8'h00, 1, TSMP + TTMO, 7, 0);     // R7 released on the last allowed cycle
      run(0, 4'hB, 8'h00, 2, 60, 8, 0);              // R7 timeout
      run(1, 4'h6, 8'h5A, 99, 99, 9, 1);             // R2 request while busy ignored
      run(0, 4'hC, 8'h00, TSMP + 1, TSMP + 4, 10, 1); // R5 dip after the sample edge
      // constrained random
      for (int t = 0; t < 40; t++) begin
         int m = int'($urandom % 4);
         int lf = 99, lt = 99;
         if (m == 1) begin
            lf = 1 + int'($urandom % TSMP);
            lt = lf + int'($urandom % (TSMP - lf + 1));
         end else if (m == 2) begin
            lf = 1 + int'($urandom % TSMP);
            lt = TSMP + 1 + int'($urandom % (TTMO + 4));
         end else if (m == 3) begin
            lf = 1 + int'($urandom % (TSTR + 2));
            lt = lf + 1 + int'($urandom % 8);
         end
         run(bit'($urandom % 2), 4'($urandom), 8'($urandom), lf, lt, 20 + t,
             bit'(($urandom % 5) == 0));
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule